// File: doc/BRIEF.md
# Prioritized Interrupt Vector Fetch Controller

This block collects interrupt requests from the core's surroundings and turns the most urgent one into a redirected instruction fetch. Requests come from two kinds of lines. Asynchronous lines come from external pins. Synchronous lines come from core conditions, on-chip peripherals and software trap instructions, and one source may drive several of these lines. Each line has its own enable. Among the enabled, pending lines, the one with the lowest index wins.

The controller waits for a fetch slot from the core. The instruction that is already decoding therefore finishes normally. When the slot comes, the controller drives a one-cycle fetch-address override and holds the program counter for that cycle. The override points at the second word of the two-word jump-to-subroutine stored in the vector table, at `TABLE_BASE + 2*index + 1`. In the same cycle it pulses a one-hot acknowledge so the source can drop its request. It then starts no new entry until the core signals a return from interrupt. While no entry is active, a wake output tells the core that an enabled request is pending, so the core can leave its low-power wait state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A pin request line passes through two flip-flops before it counts as pending. A pin line that goes high between two rising edges shows on `wake` only after the second rising edge that follows.
- R2: A request on `int_req` counts as pending in the same cycle, and `wake` responds without any clock edge.
- R3: A request whose `req_en` bit is 0 is ignored: it raises neither `wake` nor an entry. Once the enable bit is set, the request is served at the next fetch slot.
- R4: When several enabled requests are pending, the lowest index is selected. Bit i of every vector belongs to vector i.
- R5: An entry starts only at a rising edge where `fetch_slot` is 1, a request is pending and no entry is active. `fetch_valid` is high in the cycle after that edge.
- R6: While `fetch_valid` is high, `fetch_addr` equals `TABLE_BASE + 2*index + 1`, which is the second word of that vector's two-word entry.
- R7: `pc_hold` is high exactly when `fetch_valid` is high, and that cycle lasts one clock.
- R8: `ack` is one-hot on the selected vector while `fetch_valid` is high, and all zero otherwise.
- R9: After an entry, no new entry starts until `rti_strobe` has been sampled high at a rising edge following the fetch cycle.
- R10: `wake` is high whenever an enabled request is pending and no entry is active.
- R11: During and right after reset (`rst_n` low), `fetch_valid`, `pc_hold`, `ack` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_req | input | NV | Asynchronous request lines from pins, one per vector |
| int_req | input | NV | Synchronous requests from core, peripherals and software |
| req_en | input | NV | Per-vector enable |
| fetch_slot | input | 1 | Core offers the next fetch slot |
| rti_strobe | input | 1 | Return from interrupt seen by the core |
| fetch_addr | output | AW | Vector-table fetch address override |
| fetch_valid | output | 1 | Override is valid this cycle |
| pc_hold | output | 1 | Program counter must not advance |
| ack | output | NV | One-hot acknowledge of the served vector |
| wake | output | 1 | Leave the low-power wait state |

## Verification
The first pattern drives a single synchronous request without a fetch slot. This separates immediate wake from entry, which has to wait for the slot. A single pin request shows the two-edge synchronizer delay, which a one-flop or unsynchronized path would get wrong. Three requests at once at indices 7, 40 and 63 show that the lowest index is picked and that its address is formed correctly. A masked request, a request during service and a request released by a return show that the enable and the re-entry lock work. A reference model in the bench runs beside the design and checks the outputs on every clock.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt vector fetch controller.
package irq_pkg;
    // Entry sequence: waiting, issuing the vector fetch, servicing.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_SERVICE = 2'd2
    } entry_state_t;
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchronizer for a vector of asynchronous request lines.
// Assumes each line is held high long enough to be sampled.
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the raw lines through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: the lowest set bit wins.
// Assumes W >= 2 and IW = $clog2(W).
module irq_prio_enc #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest pending index is kept last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/irq_entry_fsm.sv
// Entry sequencer. It takes an interrupt at a fetch slot, issues a
// one-cycle vector fetch override with the PC held, acknowledges the
// source and then locks out new entries until a return strobe arrives.
// Assumes idx is valid whenever any is high.
module irq_entry_fsm
    import irq_pkg::*;
#(
    parameter int          NV   = 64,
    parameter int          IW   = $clog2(NV),
    parameter int          AW   = 16,
    parameter int unsigned BASE = 32'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any,
    input  logic [IW-1:0] idx,
    input  logic          fetch_slot,
    input  logic          rti_strobe,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_valid,
    output logic          pc_hold,
    output logic [NV-1:0] ack,
    output logic          wake
);
    entry_state_t state_q;
    logic [AW-1:0] addr_q;
    logic [NV-1:0] ack_q;
    logic          take;

    assign take = (state_q == ST_IDLE) && any && fetch_slot;

    // Step through idle, fetch and service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (take) state_q <= ST_FETCH;
                ST_FETCH:   state_q <= ST_SERVICE;
                ST_SERVICE: if (rti_strobe) state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the second-word address and the one-hot acknowledge on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ack_q  <= '0;
        end else if (take) begin
            addr_q <= AW'(BASE) + AW'({idx, 1'b1});
            ack_q  <= NV'(1) << idx;
        end else begin
            ack_q  <= '0;
        end
    end

    assign fetch_valid = (state_q == ST_FETCH);
    assign pc_hold     = fetch_valid;
    assign fetch_addr  = addr_q;
    assign ack         = ack_q;
    assign wake        = any && (state_q == ST_IDLE);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the prioritized interrupt vector fetch controller. It
// synchronizes pin requests, merges them with synchronous requests,
// applies per-vector enables and sequences the vector fetch.
// Assumes NV >= 2 and a vector table at BASE with two words per entry.
module irq_vector_ctrl #(
    parameter int          NV   = 64,
    parameter int          AW   = 16,
    parameter int unsigned BASE = 32'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NV-1:0] pin_req,
    input  logic [NV-1:0] int_req,
    input  logic [NV-1:0] req_en,
    input  logic          fetch_slot,
    input  logic          rti_strobe,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_valid,
    output logic          pc_hold,
    output logic [NV-1:0] ack,
    output logic          wake
);
    localparam int IW = $clog2(NV);

    logic [NV-1:0] pin_sync;
    logic [NV-1:0] pend;
    logic          any;
    logic [IW-1:0] idx;

    irq_sync #(.W(NV)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_req),
        .sync_out (pin_sync)
    );

    // Combine both request kinds and apply the enables.
    assign pend = (pin_sync | int_req) & req_en;

    irq_prio_enc #(.W(NV), .IW(IW)) u_enc (
        .pend (pend),
        .any  (any),
        .idx  (idx)
    );

    irq_entry_fsm #(.NV(NV), .IW(IW), .AW(AW), .BASE(BASE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any         (any),
        .idx         (idx),
        .fetch_slot  (fetch_slot),
        .rti_strobe  (rti_strobe),
        .fetch_addr  (fetch_addr),
        .fetch_valid (fetch_valid),
        .pc_hold     (pc_hold),
        .ack         (ack),
        .wake        (wake)
    );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Assertion checker for irq_vector_ctrl, attached through bind.
module irq_vector_ctrl_chk #(
    parameter int          NV   = 64,
    parameter int          AW   = 16,
    parameter int unsigned BASE = 32'h0100
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NV-1:0] pend,
    input logic [NV-1:0] req_en,
    input logic          rti_strobe,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_valid,
    input logic          pc_hold,
    input logic [NV-1:0] ack,
    input logic          wake
);
    logic in_svc_q;

    // Independent record of whether a service is open.
    always_ff @(posedge clk) begin
        if (!rst_n)           in_svc_q <= 1'b0;
        else if (fetch_valid) in_svc_q <= 1'b1;
        else if (rti_strobe)  in_svc_q <= 1'b0;
    end

    function automatic int unsigned bit_pos(input logic [NV-1:0] v);
        int unsigned p = 0;
        for (int i = 0; i < NV; i++) if (v[i]) p = i;
        return p;
    endfunction

    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |=> !fetch_valid); // R7
    AST_HOLD_WITH_FETCH: assert property (@(posedge clk) disable iff (!rst_n) pc_hold |-> fetch_valid); // R7
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |-> ($countones(ack) == 1)); // R8
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !fetch_valid |-> (ack == '0)); // R8
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |-> (($past(pend) & (ack - NV'(1))) == '0)); // R4
    AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |-> ((ack & $past(req_en)) != '0)); // R3
    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |-> (fetch_addr == AW'(BASE + 2 * bit_pos(ack) + 1))); // R6
    AST_WAKE_BEFORE: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |-> $past(wake)); // R10
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |-> !in_svc_q); // R9
    AST_NO_WAKE_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n) in_svc_q |-> !wake); // R10
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NV(NV), .AW(AW), .BASE(BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend        (pend),
    .req_en      (req_en),
    .rti_strobe  (rti_strobe),
    .fetch_addr  (fetch_addr),
    .fetch_valid (fetch_valid),
    .pc_hold     (pc_hold),
    .ack         (ack),
    .wake        (wake)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam int          NV = 64;
    localparam int          AW = 16;
    localparam int unsigned TB_BASE = 32'h0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] pin_req = '0;
    logic [NV-1:0] int_req = '0;
    logic [NV-1:0] req_en = '1;
    logic          fetch_slot = 1'b0;
    logic          rti_strobe = 1'b0;
    logic [AW-1:0] fetch_addr;
    logic          fetch_valid;
    logic          pc_hold;
    logic [NV-1:0] ack;
    logic          wake;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    irq_vector_ctrl #(.NV(NV), .AW(AW), .BASE(TB_BASE)) dut (
        .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .int_req(int_req),
        .req_en(req_en), .fetch_slot(fetch_slot), .rti_strobe(rti_strobe),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .pc_hold(pc_hold),
        .ack(ack), .wake(wake)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model.
    logic [NV-1:0] m_p1 = '0, m_p2 = '0, m_ack = '0;
    logic          m_busy = 0, m_fv = 0;
    int            m_addr = 0;

    always @(posedge clk) begin
        logic [NV-1:0] p;
        int k;
        p = (m_p2 | int_req) & req_en;
        k = -1;
        for (int i = NV - 1; i >= 0; i--) if (p[i]) k = i;
        if (!rst_n) begin
            m_p1 <= '0; m_p2 <= '0; m_busy <= 0; m_fv <= 0; m_ack <= '0;
        end else begin
            m_p1 <= pin_req;
            m_p2 <= m_p1;
            m_fv <= 0;
            m_ack <= '0;
            if (!m_busy && fetch_slot && k >= 0) begin
                m_fv <= 1; m_busy <= 1;
                m_ack <= 64'd1 << k;
                m_addr <= TB_BASE + 2 * k + 1;
            end else if (m_busy && !m_fv && rti_strobe) begin
                m_busy <= 0;
            end
        end
    end

    // Compare the model with the design every cycle.
    always @(negedge clk) begin
        #1;
        chk("R5 fetch_valid", 64'(fetch_valid), 64'(m_fv));
        chk("R7 pc_hold", 64'(pc_hold), 64'(m_fv));
        chk("R8 ack", ack, m_ack);
        chk("R10 wake", 64'(wake), 64'((((m_p2 | int_req) & req_en) != '0) && !m_busy));
        if (m_fv) chk("R6 fetch_addr", 64'(fetch_addr), 64'(m_addr));
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic close_service();
        rti_strobe = 1; tick(); rti_strobe = 0;
    endtask

    initial begin
        repeat (3) tick();
        #2;
        chk("R11 reset fetch_valid", 64'(fetch_valid), 0);
        chk("R11 reset pc_hold", 64'(pc_hold), 0);
        chk("R11 reset ack", ack, 0);
        chk("R11 reset wake", 64'(wake), 0);
        rst_n = 1; tick();

        // R2: synchronous request wakes at once; entry waits for a slot (R5).
        int_req[5] = 1; #2;
        chk("R2 immediate wake", 64'(wake), 1);
        tick(); #2;
        chk("R5 no slot no entry", 64'(fetch_valid), 0);
        fetch_slot = 1; tick(); #2;
        chk("R5 entry at slot", 64'(fetch_valid), 1);
        chk("R7 pc held", 64'(pc_hold), 1);
        chk("R6 addr vec5", 64'(fetch_addr), TB_BASE + 11);
        chk("R8 ack vec5", ack, 64'd1 << 5);
        int_req[5] = 0; fetch_slot = 0; tick(); #2;
        chk("R7 one cycle only", 64'(fetch_valid), 0);

        // R9: request during service is held off until the return.
        int_req[0] = 1; fetch_slot = 1; tick(); tick(); #2;
        chk("R9 held off", 64'(fetch_valid), 0);
        chk("R10 no wake in service", 64'(wake), 0);
        rti_strobe = 1; tick(); rti_strobe = 0; #2;
        chk("R9 idle after return", 64'(wake), 1);
        tick(); #2;
        chk("R9 re-entry", ack, 64'd1);
        int_req[0] = 0; fetch_slot = 0; tick(); close_service();

        // R1: pin synchronizer latency.
        pin_req[9] = 1; tick(); #2;
        chk("R1 not after one edge", 64'(wake), 0);
        tick(); #2;
        chk("R1 seen after two edges", 64'(wake), 1);
        fetch_slot = 1; tick(); #2;
        chk("R6 addr vec9", 64'(fetch_addr), TB_BASE + 19);
        pin_req[9] = 0; fetch_slot = 0; tick(); close_service();
        tick(); tick();

        // R4: simultaneous requests.
        int_req[63] = 1; int_req[40] = 1; int_req[7] = 1; fetch_slot = 1; tick(); #2;
        chk("R4 lowest wins", ack, 64'd1 << 7);
        chk("R6 addr vec7", 64'(fetch_addr), TB_BASE + 15);
        int_req = '0; fetch_slot = 0; tick(); close_service();

        // R3: masked request is ignored until enabled.
        req_en[2] = 0; int_req[2] = 1; fetch_slot = 1;
        tick(); tick(); tick(); #2;
        chk("R3 masked no wake", 64'(wake), 0);
        chk("R3 masked no entry", 64'(fetch_valid), 0);
        req_en[2] = 1; tick(); #2;
        chk("R3 served once enabled", ack, 64'd1 << 2);
        int_req = '0; fetch_slot = 0; tick(); close_service();
        tick(); tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule